// File: doc/BRIEF.md
# Counter Clock and Gate Source Router

This block sits beside a bank of counter/timer channels and decides, for every channel, where its count enable and its gate come from. The channels are organised as groups of counters, each counter holding several channels. Software configures a channel by writing one byte to a per-group clock register or a per-group gate register. That byte names the counter within the group, the channel within the counter and a source number. The counters themselves sit outside this block. They receive one single-cycle count-enable strobe and one gate level per channel.

The reference clocks are derived from the 20 MHz system clock as enable pulses, not as separate clock nets. A cascade of one divide-by-two stage and decade stages produces strobes at 10 MHz, 1 MHz, 100 kHz, 10 kHz and 1 kHz. A constant strobe stands for 20 MHz. In standard mode only the three low source bits are honoured. In enhanced mode two further bits widen the source range to 0..31. The stored selects of every channel are brought out as flat vectors.

Top module: `ctr_src_router`

## Requirements
- R1: After reset every clock select and every gate select is 0, so each channel's gate is 1 and each channel's count enable follows its own external clock input.
- R2: The clock register of group g decodes at address 0x18+g and the gate register of group g at 0x1B+g (g = 0..2). A write to any other address changes no select.
- R3: In a written byte, bit 5 picks the counter (0 or 1) and bits 4:3 the channel. Bits 2:0 are source bits 2:0 and bits 7:6 are source bits 4:3. Only the addressed channel's select of the addressed kind changes, one cycle after the write.
- R4: A write whose channel field (bits 4:3) is 3 changes no select.
- R5: With enhanced mode low, bits 7:6 are ignored and the stored source is bits 2:0 (0..7). With enhanced mode high, the full 5-bit source is stored.
- R6: Clock source 0 passes the channel's external clock input to its count enable.
- R7: Clock sources 1..5 give strobes with periods of 2, 20, 200, 2000 and 20000 system cycles. The strobe of source s is high in the cycle after n rising edges since reset release exactly when (n+1) is a multiple of its period.
- R8: Clock source 11 holds the count enable high in every cycle.
- R9: Clock sources 6..10 and 12..31 hold the count enable low.
- R10: Gate source 0 drives the gate high. Gate source 1 passes the channel's external gate input. Gate sources 2..31 drive the gate low.
- R11: Channel (g, c, h) has flat index i = (g*2+c)*3+h, and its 5-bit clock and gate selects appear on bits [5i+4:5i] of the select outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enh_mode_i | input | 1 | 1 = 5-bit source codes, 0 = 3-bit source codes |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register byte address |
| wr_data_i | input | 8 | Packed select byte |
| ext_clk_i | input | 18 | Per-channel external clock strobe (synchronous) |
| ext_gate_i | input | 18 | Per-channel external gate level (synchronous) |
| clk_en_o | output | 18 | Per-channel count-enable strobe |
| gate_o | output | 18 | Per-channel gate level |
| clk_sel_o | output | 90 | Stored clock selects, 5 bits per channel |
| gate_sel_o | output | 90 | Stored gate selects, 5 bits per channel |

## Verification
The assertions take for granted that the external clock and gate inputs are already synchronous to the system clock. They also assume that the mode input and the write port are stable around each rising edge, because the byte is decoded in the same cycle it is captured. The bench changes every input 2 ns after a rising edge: the write port, the mode bit, and a pseudo-random pattern on all external inputs that advances once per cycle. Outputs are compared on the falling edge against a model indexed by the bench's own count of rising edges since reset release.

// File: rtl/ctr_src_router_pkg.sv
package ctr_src_router_pkg;

  localparam int SRC_W = 5;
  localparam int CHF_W = 2;

  typedef struct packed {
    logic             ctr;
    logic [CHF_W-1:0] chan;
    logic [SRC_W-1:0] src;
  } sel_word_t;

  // Unpack a written select byte; standard mode drops the two high source bits.
  function automatic sel_word_t split_byte(input logic [7:0] b, input logic enh);
    sel_word_t w;
    w.ctr  = b[5];
    w.chan = b[4:3];
    w.src  = {(enh ? b[7:6] : 2'b00), b[2:0]};
    return w;
  endfunction

  // Period, in system cycles, of divider stage k.
  function automatic int stage_period(input int k, input int first, input int dec);
    int p;
    p = first;
    for (int j = 0; j < k; j++) p = p * dec;
    return p;
  endfunction

  // Gate level for a gate source code.
  function automatic logic decode_gate(input logic [SRC_W-1:0] s, input logic ext);
    if (s == '0) return 1'b1;
    if (s == SRC_W'(1)) return ext;
    return 1'b0;
  endfunction

endpackage

// File: rtl/ctr_src_router_ticks.sv
module ctr_src_router_ticks
  import ctr_src_router_pkg::*;
#(
  parameter int FIRST_DIV = 2,
  parameter int DECADE    = 10,
  parameter int NUM_DEC   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [NUM_DEC-1:0] tick_o
);

  localparam int CW0 = (FIRST_DIV > 1) ? $clog2(FIRST_DIV) : 1;
  localparam int CWD = (DECADE > 1) ? $clog2(DECADE) : 1;

  for (genvar k = 0; k < NUM_DEC; k++) begin : g_stage
    if (k == 0) begin : g_first
      logic [CW0-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else if (cnt_q == CW0'(FIRST_DIV - 1)) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o[0] = (cnt_q == CW0'(FIRST_DIV - 1));
    end else begin : g_decade
      logic [CWD-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else if (tick_o[k-1]) begin
          if (cnt_q == CWD'(DECADE - 1)) cnt_q <= '0;
          else cnt_q <= cnt_q + 1'b1;
        end
      end
      assign tick_o[k] = tick_o[k-1] && (cnt_q == CWD'(DECADE - 1));
    end

    // Spacing checker: cycles since reset or since this stage's last strobe.
    localparam int PER = stage_period(k, FIRST_DIV, DECADE);
    logic [31:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gap_q <= '0;
      else if (tick_o[k]) gap_q <= '0;
      else gap_q <= gap_q + 32'd1;
    end

    // R7
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o[k] == (gap_q == 32'(PER - 1)));
  end

endmodule

// File: rtl/ctr_src_router_regs.sv
module ctr_src_router_regs
  import ctr_src_router_pkg::*;
#(
  parameter int NUM_GRP   = 3,
  parameter int NUM_CTR   = 2,
  parameter int NUM_CHN   = 3,
  parameter int ADDR_W    = 8,
  parameter int CLK_BASE  = 'h18,
  parameter int GATE_BASE = 'h1B,
  localparam int NCH      = NUM_GRP * NUM_CTR * NUM_CHN,
  localparam int VEC_W    = NCH * SRC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enh_mode_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [VEC_W-1:0]  clk_sel_o,
  output logic [VEC_W-1:0]  gate_sel_o
);

  sel_word_t          fld;
  logic               fld_ok;
  logic [NUM_GRP-1:0] clk_grp_hit;
  logic [NUM_GRP-1:0] gate_grp_hit;
  logic [NCH-1:0]     clk_wr_stb;
  logic [NCH-1:0]     gate_wr_stb;
  logic [VEC_W-1:0]   clk_sel_q;
  logic [VEC_W-1:0]   gate_sel_q;

  assign fld    = split_byte(wr_data_i, enh_mode_i);
  assign fld_ok = (int'(fld.chan) < NUM_CHN) && (int'(fld.ctr) < NUM_CTR);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign clk_grp_hit[g]  = wr_en_i && (wr_addr_i == ADDR_W'(CLK_BASE + g));
    assign gate_grp_hit[g] = wr_en_i && (wr_addr_i == ADDR_W'(GATE_BASE + g));
    for (genvar c = 0; c < NUM_CTR; c++) begin : g_ctr
      for (genvar h = 0; h < NUM_CHN; h++) begin : g_chn
        localparam int IDX = (g * NUM_CTR + c) * NUM_CHN + h;
        logic addr_match;
        assign addr_match       = fld_ok && (fld.ctr == 1'(c)) && (fld.chan == CHF_W'(h));
        assign clk_wr_stb[IDX]  = clk_grp_hit[g] && addr_match;
        assign gate_wr_stb[IDX] = gate_grp_hit[g] && addr_match;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sel_q  <= '0;
      gate_sel_q <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (clk_wr_stb[i])  clk_sel_q[i*SRC_W +: SRC_W]  <= fld.src;
        if (gate_wr_stb[i]) gate_sel_q[i*SRC_W +: SRC_W] <= fld.src;
      end
    end
  end

  assign clk_sel_o  = clk_sel_q;
  assign gate_sel_o = gate_sel_q;

  // R4
  chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !fld_ok) |=> ($stable(clk_sel_o) && $stable(gate_sel_o)));

  // R2
  stray_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !(|clk_grp_hit) && !(|gate_grp_hit)) |=>
      ($stable(clk_sel_o) && $stable(gate_sel_o)));

  for (genvar i = 0; i < NCH; i++) begin : g_std
    // R5
    std_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((clk_wr_stb[i] || gate_wr_stb[i]) && !enh_mode_i) |=>
        (clk_sel_o[i*SRC_W+3 +: 2] == 2'b00 || !$past(clk_wr_stb[i])) &&
        (gate_sel_o[i*SRC_W+3 +: 2] == 2'b00 || !$past(gate_wr_stb[i])));
  end

endmodule

// File: rtl/ctr_src_router_mux.sv
module ctr_src_router_mux
  import ctr_src_router_pkg::*;
#(
  parameter int NCH      = 18,
  parameter int NUM_DEC  = 5,
  parameter int FAST_SRC = 11,
  localparam int VEC_W   = NCH * SRC_W
) (
  input  logic [NUM_DEC-1:0] ticks_i,
  input  logic [NCH-1:0]     ext_clk_i,
  input  logic [NCH-1:0]     ext_gate_i,
  input  logic [VEC_W-1:0]   clk_sel_i,
  input  logic [VEC_W-1:0]   gate_sel_i,
  output logic [NCH-1:0]     clk_en_o,
  output logic [NCH-1:0]     gate_o
);

  // Count-enable for a clock source code: external, divided, fast, or idle.
  function automatic logic pick_clock(input logic [SRC_W-1:0] s, input logic ext,
                                      input logic [NUM_DEC-1:0] t);
    logic r;
    r = 1'b0;
    if (s == '0) r = ext;
    else if (s == SRC_W'(FAST_SRC)) r = 1'b1;
    else begin
      for (int k = 0; k < NUM_DEC; k++)
        if (s == SRC_W'(k + 1)) r = t[k];
    end
    return r;
  endfunction

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic [SRC_W-1:0] cs;
    logic [SRC_W-1:0] gs;
    assign cs          = clk_sel_i[i*SRC_W +: SRC_W];
    assign gs          = gate_sel_i[i*SRC_W +: SRC_W];
    assign clk_en_o[i] = pick_clock(cs, ext_clk_i[i], ticks_i);
    assign gate_o[i]   = decode_gate(gs, ext_gate_i[i]);
  end

endmodule

// File: rtl/ctr_src_router.sv
module ctr_src_router
  import ctr_src_router_pkg::*;
#(
  parameter int NUM_GRP   = 3,
  parameter int NUM_CTR   = 2,
  parameter int NUM_CHN   = 3,
  parameter int ADDR_W    = 8,
  parameter int CLK_BASE  = 'h18,
  parameter int GATE_BASE = 'h1B,
  parameter int FIRST_DIV = 2,
  parameter int DECADE    = 10,
  parameter int NUM_DEC   = 5,
  parameter int FAST_SRC  = 11,
  localparam int NCH      = NUM_GRP * NUM_CTR * NUM_CHN,
  localparam int VEC_W    = NCH * SRC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enh_mode_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [NCH-1:0]    ext_clk_i,
  input  logic [NCH-1:0]    ext_gate_i,
  output logic [NCH-1:0]    clk_en_o,
  output logic [NCH-1:0]    gate_o,
  output logic [VEC_W-1:0]  clk_sel_o,
  output logic [VEC_W-1:0]  gate_sel_o
);

  logic [NUM_DEC-1:0] ref_ticks;

  ctr_src_router_ticks #(
    .FIRST_DIV (FIRST_DIV),
    .DECADE    (DECADE),
    .NUM_DEC   (NUM_DEC)
  ) u_ticks (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (ref_ticks)
  );

  ctr_src_router_regs #(
    .NUM_GRP   (NUM_GRP),
    .NUM_CTR   (NUM_CTR),
    .NUM_CHN   (NUM_CHN),
    .ADDR_W    (ADDR_W),
    .CLK_BASE  (CLK_BASE),
    .GATE_BASE (GATE_BASE)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .enh_mode_i (enh_mode_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .clk_sel_o  (clk_sel_o),
    .gate_sel_o (gate_sel_o)
  );

  ctr_src_router_mux #(
    .NCH      (NCH),
    .NUM_DEC  (NUM_DEC),
    .FAST_SRC (FAST_SRC)
  ) u_mux (
    .ticks_i    (ref_ticks),
    .ext_clk_i  (ext_clk_i),
    .ext_gate_i (ext_gate_i),
    .clk_sel_i  (clk_sel_o),
    .gate_sel_i (gate_sel_o),
    .clk_en_o   (clk_en_o),
    .gate_o     (gate_o)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    logic [SRC_W-1:0] cs;
    logic [SRC_W-1:0] gs;
    assign cs = clk_sel_o[i*SRC_W +: SRC_W];
    assign gs = gate_sel_o[i*SRC_W +: SRC_W];

    // R6
    ext_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs == '0) |-> (clk_en_o[i] == ext_clk_i[i]));

    // R8
    fast_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs == SRC_W'(FAST_SRC)) |-> clk_en_o[i]);

    // R9
    idle_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cs) > NUM_DEC && cs != SRC_W'(FAST_SRC)) |-> !clk_en_o[i]);

    // R10
    gate_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gs == '0) |-> gate_o[i]);
  end

endmodule

// File: tb/ctr_src_router_tb_top.sv
module ctr_src_router_tb_top;
  localparam int NG = 3, NC = 2, NH = 3, NCH = 18, SW = 5;

  logic clk = 1'b0, rst_n = 1'b0, enh = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic [NCH-1:0] ext_clk, ext_gate, clk_en, gate;
  logic [NCH*SW-1:0] clk_sel, gate_sel;

  always #5 clk = ~clk;

  ctr_src_router dut_i (
    .clk(clk), .rst_n(rst_n), .enh_mode_i(enh), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .ext_clk_i(ext_clk),
    .ext_gate_i(ext_gate), .clk_en_o(clk_en), .gate_o(gate),
    .clk_sel_o(clk_sel), .gate_sel_o(gate_sel)
  );

  int checks = 0, errors = 0;
  string phase = "R1";
  bit chk_on = 0, done = 0;
  longint cyc = 0;
  int m_clk[NCH];
  int m_gate[NCH];
  logic [31:0] lfsr = 32'hACE1_2357;

  assign ext_clk  = lfsr[17:0];
  assign ext_gate = lfsr[31:14];

  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  end

  // Bench model of the selects, from the address map and byte fields.
  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0;
      for (int i = 0; i < NCH; i++) begin m_clk[i] = 0; m_gate[i] = 0; end
    end else begin
      cyc++;
      if (wr_en) begin
        int a, d, h, c, s;
        a = int'(wr_addr); d = int'(wr_data);
        h = (d >> 3) & 3; c = (d >> 5) & 1;
        s = enh ? (((d >> 6) & 3) * 8 + (d & 7)) : (d & 7);
        if (h < NH) begin
          if (a >= 24 && a < 24 + NG) m_clk[((a - 24) * NC + c) * NH + h] = s;
          else if (a >= 27 && a < 27 + NG) m_gate[((a - 27) * NC + c) * NH + h] = s;
        end
      end
    end
  end

  function automatic longint per(int s);
    longint p = 2;
    for (int k = 1; k < s; k++) p = p * 10;
    return p;
  endfunction

  function automatic logic exp_clk(int i);
    int s = m_clk[i];
    if (s == 0) return ext_clk[i];
    if (s <= 5) return ((cyc + 1) % per(s)) == 0;
    if (s == 11) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic exp_gate(int i);
    int s = m_gate[i];
    if (s == 0) return 1'b1;
    if (s == 1) return ext_gate[i];
    return 1'b0;
  endfunction

  function automatic string clk_req(int s);
    if (s == 0) return "R6";
    if (s <= 5) return "R7";
    if (s == 11) return "R8";
    return "R9";
  endfunction

  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      logic [NCH*SW-1:0] ecs, egs;
      bit bad_c, bad_g;
      for (int i = 0; i < NCH; i++) begin
        ecs[i*SW +: SW] = SW'(m_clk[i]);
        egs[i*SW +: SW] = SW'(m_gate[i]);
      end
      checks += 4;
      if (clk_sel !== ecs) begin
        errors++;
        $display("FAIL %s R11 clk_sel got %h exp %h", phase, clk_sel, ecs);
      end
      if (gate_sel !== egs) begin
        errors++;
        $display("FAIL %s R11 gate_sel got %h exp %h", phase, gate_sel, egs);
      end
      bad_c = 0; bad_g = 0;
      for (int i = 0; i < NCH; i++) begin
        if (!bad_c && clk_en[i] !== exp_clk(i)) begin
          bad_c = 1; errors++;
          $display("FAIL %s clk_en ch%0d src%0d cyc%0d got %b exp %b",
                   clk_req(m_clk[i]), i, m_clk[i], cyc, clk_en[i], exp_clk(i));
        end
        if (!bad_g && gate[i] !== exp_gate(i)) begin
          bad_g = 1; errors++;
          $display("FAIL R10 gate ch%0d src%0d got %b exp %b",
                   i, m_gate[i], gate[i], exp_gate(i));
        end
      end
    end
  end

  function automatic logic [7:0] enc(int c, int h, int s);
    return {2'(s >> 3), 1'(c), 2'(h), 3'(s)};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    checks++;
    if (clk_sel !== '0 || gate_sel !== '0 || gate !== '1 || clk_en !== ext_clk) begin
      errors++;
      $display("FAIL R1 reset sel %h/%h gate %h clk_en %h exp 0/0/3ffff ext %h",
               clk_sel, gate_sel, gate, clk_en, ext_clk);
    end
    chk_on = 1;
    @(posedge clk); #2 enh = 1'b1;

    // R3: every channel, every clock source, enhanced mode
    phase = "R3";
    for (int g = 0; g < NG; g++)
      for (int c = 0; c < NC; c++)
        for (int h = 0; h < NH; h++)
          for (int s = 0; s < 32; s++) begin
            wr(8'(24 + g), enc(c, h, s)); idle(1);
          end

    // R10: every channel, every gate source
    phase = "R10";
    for (int g = 0; g < NG; g++)
      for (int c = 0; c < NC; c++)
        for (int h = 0; h < NH; h++)
          for (int s = 0; s < 32; s++) begin
            wr(8'(27 + g), enc(c, h, s)); idle(1);
          end

    // R5: standard mode drops bits 7:6
    phase = "R5";
    @(posedge clk); #2 enh = 1'b0;
    for (int g = 0; g < NG; g++)
      for (int c = 0; c < NC; c++)
        for (int h = 0; h < NH; h++) begin
          for (int s = 0; s < 8; s++) wr(8'(24 + g), enc(c, h, 24 + s));
          wr(8'(27 + g), enc(c, h, 25));
        end
    @(posedge clk); #2 enh = 1'b1;

    // R4: channel field 3 is ignored
    phase = "R4";
    for (int a = 24; a < 30; a++)
      for (int v = 0; v < 16; v++) wr(8'(a), 8'((v * 37) | 8'h18));

    // R2: stray addresses
    phase = "R2";
    for (int a = 0; a < 256; a++)
      if (a < 24 || a > 29) wr(8'(a), (a % 2 == 0) ? 8'hED : 8'h05);

    // R7: divided strobes over long windows, plus R8 and R6 on neighbours
    phase = "R7";
    wr(8'h18, enc(0, 0, 1)); wr(8'h18, enc(0, 1, 2)); wr(8'h18, enc(0, 2, 3));
    wr(8'h18, enc(1, 0, 4)); wr(8'h18, enc(1, 1, 5)); wr(8'h18, enc(1, 2, 11));
    wr(8'h19, enc(0, 0, 0)); wr(8'h1C, enc(0, 0, 1)); wr(8'h1D, enc(1, 2, 1));
    idle(42000);

    chk_on = 0; done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired in phase %s", phase);
      summary();
      $finish;
    end
  end

endmodule